// File: doc/BRIEF.md
# Class-Partitioned Virtual Channel Allocator

This block hands out downstream virtual channels (VCs) on a router's output ports to head flits that want them. Each requesting input VC gives the output port it is headed for and its traffic class: request (class 0) or reply (class 1). The class limits which downstream VCs the packet may claim. Each output port has a fixed policy chosen by parameter. **Split** divides the VCs evenly between the two classes. **Shared** lets either class take any VC. **Skewed** keeps a small number of VCs for requests and gives the rest to replies.

Because the policy is set per port, one router can share VCs on its vertical links and keep the class split on its horizontal links. The horizontal links are where request and reply traffic mix, so keeping the split there is what avoids protocol deadlock. The block also keeps a credit counter for every downstream VC. A VC counts as held from its allocation until the tail flit has left. After that, it becomes allocatable again only once every credit has come back.

The grant is combinational, so it appears in the same cycle as the request. The allocation takes effect at the next clock edge. A requester drops its request once it has been granted.

Top module: `vc_class_alloc`

## Requirements
- R1: After reset every downstream VC is free, holds DEPTH credits with `credit_ok` high, and no grant is raised while no request is present.
- R2: On a split port (policy 0), requests may only get VCs 0..VCS/2-1 and replies only VCs VCS/2..VCS-1.
- R3: On a shared port (policy 1), a request of either class may get any VC.
- R4: On a skewed port (policy 2), requests may only get VCs 0..SKEW_REQ-1 and replies only the remaining VCs.
- R5: A grant names only a VC that is free in that cycle. A granted VC stays held, and is not granted again, until a flit marked as tail is sent on it.
- R6: A VC whose tail flit has left becomes allocatable only after its credit count has returned to DEPTH.
- R7: Each sent flit takes one credit from its VC and each returned credit adds one. `credit_ok` is low exactly when the count is zero.
- R8: A class with no free eligible VC gets no grant. It never takes a VC reserved for the other class.
- R9: Within a port, the choice among free eligible VCs starts at a per-port pointer. After each grant the pointer moves to one past the granted VC, wrapping around.
- R10: When several input VCs target the same downstream VC in one cycle, exactly one wins. The winner is chosen round-robin from a pointer kept per downstream VC, which moves past the winner.
- R11: `gnt[i]` is raised only while `req_valid[i]` is high. It comes in the same cycle, with `gnt_vc` giving the VC index within the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_IN | Head flit of input VC i wants a downstream VC |
| req_port | input | NUM_IN*PORT_W | Target output port of each requester |
| req_cls | input | NUM_IN | Class of each requester, 0 = request, 1 = reply |
| snd_valid | input | NUM_OUT*VCS | A flit leaves on downstream VC (port*VCS+vc) |
| snd_tail | input | NUM_OUT*VCS | That departing flit is a tail flit |
| crd_ret | input | NUM_OUT*VCS | One credit returns for the downstream VC |
| gnt | output | NUM_IN | Requester i is granted a VC this cycle |
| gnt_vc | output | NUM_IN*VC_W | Granted VC index within the target port |
| credit_ok | output | NUM_OUT*VCS | Downstream VC has at least one credit |

## Verification
On every cycle, the assertions check the following. A grant never goes to a VC outside the requester's class mask or to a busy VC, and it always has a request behind it. No downstream VC is won by two inputs at once. A held VC stays held until its tail departs, and credit counts stay in range. Only the bench's scenarios can show the rest: the exact round-robin order within a port and across inputs, the wait on a zero credit count after the tail has left, and the release that follows the last credit returning.

// File: rtl/vca_pkg.sv
package vca_pkg;

  typedef enum logic [1:0] {
    POL_SPLIT  = 2'd0,
    POL_SHARED = 2'd1,
    POL_SKEW   = 2'd2
  } vca_policy_e;

  // Set of VCs a class may claim on a port with the given policy.
  function automatic logic [31:0] class_mask(input logic [1:0] pol, input logic cls,
                                             input int vcs, input int skew_req);
    logic [31:0] m;
    int lim;
    m = '0;
    lim = (pol == POL_SKEW) ? skew_req : vcs / 2;
    for (int v = 0; v < 32; v++) begin
      if (v < vcs) begin
        if (pol == POL_SHARED) m[v] = 1'b1;
        else if (cls) m[v] = (v >= lim);
        else m[v] = (v < lim);
      end
    end
    return m;
  endfunction

  // Next round-robin pointer value after index idx in a ring of n entries.
  function automatic int ring_next(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         any,
  output logic [W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int s = 0; s < N; s++) begin
      if (!any && req[(int'(ptr) + s) % N]) begin
        any = 1'b1;
        idx = W'((int'(ptr) + s) % N);
      end
    end
  end

endmodule

// File: rtl/vca_vc_state.sv
module vca_vc_state #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          snd,
  input  logic          tail,
  input  logic          ret,
  output logic          free,
  output logic          held,
  output logic          credit_ok,
  output logic [CW-1:0] credits
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else if (alloc) held <= 1'b1;
    else if (snd && tail) held <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credits <= FULL;
    else begin
      case ({snd, ret})
        2'b10:   credits <= credits - 1'b1;
        2'b01:   credits <= credits + 1'b1;
        default: credits <= credits;
      endcase
    end
  end

  assign free      = !held && (credits == FULL);
  assign credit_ok = (credits != '0);

endmodule

// File: rtl/vc_class_alloc.sv
module vc_class_alloc #(
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 3,
  parameter int VCS      = 4,
  parameter int DEPTH    = 4,
  parameter int SKEW_REQ = 1,
  parameter logic [2*NUM_OUT-1:0] PORT_POL = 6'b10_01_00,
  parameter int PORT_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  parameter int VC_W     = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IN-1:0]          req_valid,
  input  logic [NUM_IN*PORT_W-1:0]   req_port,
  input  logic [NUM_IN-1:0]          req_cls,
  input  logic [NUM_OUT*VCS-1:0]     snd_valid,
  input  logic [NUM_OUT*VCS-1:0]     snd_tail,
  input  logic [NUM_OUT*VCS-1:0]     crd_ret,
  output logic [NUM_IN-1:0]          gnt,
  output logic [NUM_IN*VC_W-1:0]     gnt_vc,
  output logic [NUM_OUT*VCS-1:0]     credit_ok
);
  import vca_pkg::*;

  localparam int NUM_K = NUM_OUT * VCS;
  localparam int IN_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic [NUM_K-1:0]    free_vec;
  logic [NUM_K-1:0]    held_vec;
  logic [NUM_K-1:0]    alloc_vec;
  logic [NUM_K*CW-1:0] crd_vec;

  logic             pick_ok [NUM_OUT][2];
  logic [VC_W-1:0]  pick_vc [NUM_OUT][2];
  logic [VC_W-1:0]  port_ptr [NUM_OUT];
  logic [IN_W-1:0]  vc_ptr [NUM_K];
  logic [IN_W-1:0]  win_idx [NUM_K];
  logic [NUM_IN-1:0] cont [NUM_K];

  // Per downstream VC: hold flag and credit counter.
  for (genvar k = 0; k < NUM_K; k++) begin : g_vc
    vca_vc_state #(.DEPTH(DEPTH), .CW(CW)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc_vec[k]),
      .snd      (snd_valid[k]),
      .tail     (snd_tail[k]),
      .ret      (crd_ret[k]),
      .free     (free_vec[k]),
      .held     (held_vec[k]),
      .credit_ok(credit_ok[k]),
      .credits  (crd_vec[k*CW +: CW])
    );
  end

  // Stage 1: per port and class, pick one free eligible VC from the port pointer.
  for (genvar p = 0; p < NUM_OUT; p++) begin : g_port
    for (genvar c = 0; c < 2; c++) begin : g_cls
      localparam logic [VCS-1:0] MSK =
        VCS'(class_mask(PORT_POL[2*p +: 2], 1'(c), VCS, SKEW_REQ));
      vca_rr_arb #(.N(VCS), .W(VC_W)) u_pick (
        .req(free_vec[p*VCS +: VCS] & MSK),
        .ptr(port_ptr[p]),
        .any(pick_ok[p][c]),
        .idx(pick_vc[p][c])
      );
    end

    logic got_rep, got_req;
    assign got_rep = pick_ok[p][1] && alloc_vec[p*VCS + int'(pick_vc[p][1])];
    assign got_req = pick_ok[p][0] && alloc_vec[p*VCS + int'(pick_vc[p][0])];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_ptr[p] <= '0;
      else if (got_rep) port_ptr[p] <= VC_W'(ring_next(int'(pick_vc[p][1]), VCS));
      else if (got_req) port_ptr[p] <= VC_W'(ring_next(int'(pick_vc[p][0]), VCS));
    end
  end

  // Stage 2: per downstream VC, arbitrate among inputs whose pick landed on it.
  for (genvar k = 0; k < NUM_K; k++) begin : g_vcarb
    localparam int KP = k / VCS;
    localparam int KV = k % VCS;

    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        cont[k][i] = req_valid[i]
                  && (req_port[i*PORT_W +: PORT_W] == PORT_W'(KP))
                  && pick_ok[KP][req_cls[i]]
                  && (pick_vc[KP][req_cls[i]] == VC_W'(KV));
      end
    end

    vca_rr_arb #(.N(NUM_IN), .W(IN_W)) u_arb (
      .req(cont[k]),
      .ptr(vc_ptr[k]),
      .any(alloc_vec[k]),
      .idx(win_idx[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vc_ptr[k] <= '0;
      else if (alloc_vec[k]) vc_ptr[k] <= IN_W'(ring_next(int'(win_idx[k]), NUM_IN));
    end
  end

  // Grant fan-back: each input targets one VC at most, so at most one hit.
  always_comb begin
    gnt    = '0;
    gnt_vc = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      for (int k = 0; k < NUM_K; k++) begin
        if (alloc_vec[k] && (int'(win_idx[k]) == i)) begin
          gnt[i]                  = 1'b1;
          gnt_vc[i*VC_W +: VC_W]  = VC_W'(k % VCS);
        end
      end
    end
  end

endmodule

// File: rtl/vc_class_alloc_chk.sv
module vc_class_alloc_chk #(
  parameter int NUM_IN   = 4,
  parameter int NUM_OUT  = 3,
  parameter int VCS      = 4,
  parameter int DEPTH    = 4,
  parameter int SKEW_REQ = 1,
  parameter logic [2*NUM_OUT-1:0] PORT_POL = 6'b10_01_00,
  parameter int PORT_W   = 2,
  parameter int VC_W     = 2,
  parameter int CW       = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_IN-1:0]        req_valid,
  input logic [NUM_IN*PORT_W-1:0] req_port,
  input logic [NUM_IN-1:0]        req_cls,
  input logic [NUM_OUT*VCS-1:0]   snd_valid,
  input logic [NUM_OUT*VCS-1:0]   snd_tail,
  input logic [NUM_IN-1:0]        gnt,
  input logic [NUM_IN*VC_W-1:0]   gnt_vc,
  input logic [NUM_OUT*VCS-1:0]   credit_ok,
  input logic [NUM_OUT*VCS-1:0]   free_vec,
  input logic [NUM_OUT*VCS-1:0]   held_vec,
  input logic [NUM_OUT*VCS-1:0]   alloc_vec,
  input logic [NUM_OUT*VCS*CW-1:0] crd_vec
);
  import vca_pkg::*;
  localparam int NUM_K = NUM_OUT * VCS;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [31:0] msk;
    int          slot;
    always_comb begin
      msk  = class_mask(PORT_POL[2*int'(req_port[i*PORT_W +: PORT_W]) +: 2],
                        req_cls[i], VCS, SKEW_REQ);
      slot = int'(req_port[i*PORT_W +: PORT_W]) * VCS + int'(gnt_vc[i*VC_W +: VC_W]);
    end

    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> req_valid[i]);  // R11
    AST_GNT_IN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> msk[gnt_vc[i*VC_W +: VC_W]]);  // R8
    AST_GNT_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> free_vec[slot]);  // R5
  end

  for (genvar k = 0; k < NUM_K; k++) begin : g_k
    logic [NUM_IN-1:0] hits;
    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        hits[i] = gnt[i] && (int'(req_port[i*PORT_W +: PORT_W]) * VCS
                             + int'(gnt_vc[i*VC_W +: VC_W]) == k);
      end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits));  // R10
    AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[k] |=> held_vec[k]);  // R5
    AST_HOLD_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      held_vec[k] && !(snd_valid[k] && snd_tail[k]) |=> held_vec[k]);  // R5
    AST_CREDIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(crd_vec[k*CW +: CW]) <= DEPTH);  // R7
    AST_SEND_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      snd_valid[k] |-> credit_ok[k]);  // R7
  end

endmodule

bind vc_class_alloc vc_class_alloc_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .VCS(VCS), .DEPTH(DEPTH),
  .SKEW_REQ(SKEW_REQ), .PORT_POL(PORT_POL), .PORT_W(PORT_W), .VC_W(VC_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
  .req_cls(req_cls), .snd_valid(snd_valid), .snd_tail(snd_tail), .gnt(gnt),
  .gnt_vc(gnt_vc), .credit_ok(credit_ok), .free_vec(free_vec),
  .held_vec(held_vec), .alloc_vec(alloc_vec), .crd_vec(crd_vec)
);

// File: tb/vc_class_alloc_tb_top.sv
module vc_class_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4, NO = 3, NV = 4, NK = NO * NV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]   req_valid;
  logic [NI*2-1:0] req_port;
  logic [NI-1:0]   req_cls;
  logic [NK-1:0]   snd_valid, snd_tail, crd_ret;
  logic [NI-1:0]   gnt;
  logic [NI*2-1:0] gnt_vc;
  logic [NK-1:0]   credit_ok;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_class_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_cls(req_cls), .snd_valid(snd_valid), .snd_tail(snd_tail),
    .crd_ret(crd_ret), .gnt(gnt), .gnt_vc(gnt_vc), .credit_ok(credit_ok)
  );

  // {port[1:0], class, expect_grant, expect_vc[1:0]}: port0 split, port1 shared, port2 skewed.
  localparam logic [5:0] TBL [17] = '{
    6'b00_0_1_00, 6'b00_1_1_10, 6'b00_0_1_01, 6'b00_0_0_00, 6'b00_1_1_11, 6'b00_1_0_00,
    6'b01_1_1_00, 6'b01_0_1_01, 6'b01_0_1_10, 6'b01_1_1_11, 6'b01_0_0_00,
    6'b10_1_1_01, 6'b10_0_1_00, 6'b10_0_0_00, 6'b10_1_1_10, 6'b10_1_1_11, 6'b10_1_0_00
  };

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = '0; req_port = '0; req_cls = '0;
    snd_valid = '0; snd_tail = '0; crd_ret = '0;
  endtask

  task automatic req_one(input int idx, input int port, input int cls,
                         input int ok, input int vc, input string r);
    @(negedge clk);
    idle();
    req_valid[idx] = 1'b1;
    req_port[idx*2 +: 2] = 2'(port);
    req_cls[idx] = 1'(cls);
    #1;
    check(r, int'(gnt[idx]), ok);
    if (ok != 0) check(r, int'(gnt_vc[idx*2 +: 2]), vc);
  endtask

  task automatic send(input int k, input bit tail);
    @(negedge clk); idle(); snd_valid[k] = 1'b1; snd_tail[k] = tail;
  endtask

  task automatic ret(input int k);
    @(negedge clk); idle(); crd_ret[k] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    do_reset();
    // R1: reset state
    @(negedge clk); #1;
    check("R1 credit_ok", int'(credit_ok), (1 << NK) - 1);
    check("R1 no grant", int'(gnt), 0);

    // Table walk: class masks per policy, port rotation, waiting class.
    for (int t = 0; t < 17; t++) begin
      string tag;
      if (TBL[t][2] == 1'b0) tag = "R8 wait";
      else if (TBL[t][5:4] == 2'd0) tag = "R2 split";
      else if (TBL[t][5:4] == 2'd1) tag = "R3 shared";
      else tag = "R4 skew";
      req_one(t % NI, int'(TBL[t][5:4]), int'(TBL[t][3]), int'(TBL[t][2]),
              int'(TBL[t][1:0]), tag);
    end

    // Credits and release order.
    do_reset();
    req_one(0, 0, 0, 1, 0, "R9 first pick");
    req_one(1, 0, 0, 1, 1, "R9 rotated pick");
    send(0, 1'b0); send(0, 1'b0); send(0, 1'b0); send(0, 1'b1);
    @(negedge clk); idle(); #1;
    check("R7 credits empty", int'(credit_ok[0]), 0);
    check("R7 other vc", int'(credit_ok[1]), 1);
    req_one(2, 0, 0, 0, 0, "R6 no credits back");
    ret(0); ret(0); ret(0);
    @(negedge clk); idle(); #1;
    check("R7 credit back", int'(credit_ok[0]), 1);
    req_one(2, 0, 0, 0, 0, "R6 partial credits");
    ret(0);
    req_one(2, 0, 0, 1, 0, "R6 release");

    // Held without tail stays held.
    send(1, 1'b0); ret(1);
    req_one(3, 0, 0, 0, 0, "R5 held w/o tail");
    send(1, 1'b1); ret(1);
    req_one(3, 0, 0, 1, 1, "R5 tail frees");

    // Competing inputs on one VC (port2 requests: only VC0 eligible).
    do_reset();
    @(negedge clk); idle();
    req_valid = 4'b0011; req_port = 8'b00_00_10_10; req_cls = '0;
    #1;
    check("R10 first winner", int'(gnt), 1);
    check("R11 vc index", int'(gnt_vc[1:0]), 0);
    send(8, 1'b1); ret(8);
    @(negedge clk); idle();
    req_valid = 4'b0011; req_port = 8'b00_00_10_10; req_cls = '0;
    #1;
    check("R10 rotated winner", int'(gnt), 2);
    @(negedge clk); idle(); #1;
    check("R11 no req no grant", int'(gnt), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule